// File: doc/BRIEF.md
# Thermal Trip Fan Override

This block watches a stream of 8-bit signed temperature readings, each tagged as coming from the on-die sensor (internal channel) or from the remote diode (remote channel). It compares every reading against the active trip limit of its channel. Each channel holds its own trip state. A channel trips after three consecutive readings above its limit. It releases only after three consecutive readings at least five degrees below that limit.

While either channel is tripped, the block drives its overtemperature outputs low. It also forces the fan-speed code to full scale and forces the fan-enable level high. When both channels have released, the fan code returns to whatever software last programmed, and the fan-enable level returns to its value from before the trip.

Two pairs of limits exist. A fixed pair of defaults is active at reset. A software-writable pair becomes active once a write-once lock bit is set, and that lock also freezes the writable pair until the next reset. The reading stream never applies back-pressure: `smp_ready` is held high, and a reading is consumed in every cycle where `smp_valid` is high.

Top module: `thermtrip_fan_guard`

## Requirements
- R1: After reset, both overtemperature outputs and `irq_therm_n` are high and `fan_code` is 0x00. `fan_off_n` is low (fan-off requested), `alert_ext` and `therm_evt` are low, and the lock is clear.
- R2: While the lock is clear, the active limits are +70 for the internal channel (`smp_chan`=0) and +100 for the remote channel (`smp_chan`=1). A reading equal to the limit does not count as over.
- R3: Register writes use `wr_addr`, with codes 0 = fan code, 1 = configuration, 2 = internal user limit and 3 = remote user limit. The user limits reset to +127 (internal) and +100 (remote). They can be written only while the lock is clear. Configuration bit 3 sets the lock. A configuration write with bit 3 clear leaves the lock set, and only reset clears it. While the lock is set, the user limits are the active ones.
- R4: A channel trips when three consecutive readings of that channel are strictly greater than its active limit, using a signed compare. A reading not above the limit restarts the count. Readings of the other channel, and cycles with no reading, neither advance nor restart the count.
- R5: A tripped channel releases after three consecutive readings of that channel that are less than or equal to (limit − 5). When the limit is below −123, the release threshold saturates at −128. A reading above that threshold restarts the count.
- R6: `therm_a_n` and `therm_b_n` are low together, and `irq_therm_n` is low, exactly while at least one channel is tripped.
- R7: While any channel is tripped, `fan_code` is 0xFF. At other times it equals the last value written to address 0, including a value written during the trip.
- R8: `fan_off_n` is high while any channel is tripped. At other times it equals the stored fan-enable bit, which is configuration bit 5. A configuration write made while tripped leaves that stored bit unchanged.
- R9: `alert_ext` is high exactly while the remote channel is tripped. `therm_evt` pulses high for one cycle in the cycle after the edge at which the tripped condition first becomes true.
- R10: `smp_ready` is always high, and every cycle with `smp_valid` high consumes exactly one reading. Outputs reflect a reading or write one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Reading present this cycle |
| smp_ready | output | 1 | Always high; no back-pressure |
| smp_chan | input | 1 | 0 = internal sensor, 1 = remote diode |
| smp_temp | input | 8 | Two's-complement reading in degrees |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 fan code, 1 config, 2 internal limit, 3 remote limit |
| wr_data | input | 8 | Write data |
| therm_a_n | output | 1 | Active-low overtemperature output |
| therm_b_n | output | 1 | Second active-low overtemperature output |
| irq_therm_n | output | 1 | Active-low interrupt contribution from the trip |
| fan_code | output | 8 | Effective fan DAC code |
| fan_off_n | output | 1 | Low requests fan off; high lets the fan run |
| alert_ext | output | 1 | Remote channel currently tripped |
| therm_evt | output | 1 | One-cycle pulse when the trip asserts |

## Verification
The embedded properties assume that `rst_n` is driven low at start-up, and that readings and writes are presented as single-cycle pulses that are synchronous to `clk`. The bench meets this by changing every input only on the falling edge, with at most one reading or one write in each cycle. The random phase keeps readings close to the default limits, so that trip and release sequences happen many times. It also leaves idle cycles and readings from the other channel between the readings of a channel, which exercises the rule that these do not restart the count. Directed cases cover the equal-to-limit boundary, writes made while the lock is set or while tripped, and saturation of the release threshold at −128.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
  typedef logic signed [7:0] temp_t;

  typedef enum logic [1:0] {
    WA_FAN  = 2'd0,
    WA_CFG  = 2'd1,
    WA_LINT = 2'd2,
    WA_LEXT = 2'd3
  } wr_addr_e;

  localparam int CFG_LOCK_BIT = 3;
  localparam int CFG_FAN_BIT  = 5;
  localparam int NCHAN        = 2;
  localparam int CH_INT       = 0;
  localparam int CH_EXT       = 1;
endpackage

// File: rtl/tt_limit_bank.sv
module tt_limit_bank
  import thermtrip_pkg::*;
#(
  parameter int DEF_INT = 70,
  parameter int DEF_EXT = 100,
  parameter int RST_INT = 127,
  parameter int RST_EXT = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NCHAN-1:0][7:0] lim_vec,
  output logic                  locked
);
  localparam logic [7:0] DEF_INT_B = 8'(DEF_INT);
  localparam logic [7:0] DEF_EXT_B = 8'(DEF_EXT);
  localparam logic [7:0] RST_INT_B = 8'(RST_INT);
  localparam logic [7:0] RST_EXT_B = 8'(RST_EXT);

  logic [7:0] usr_int, usr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_int <= RST_INT_B;
      usr_ext <= RST_EXT_B;
      locked  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == WA_CFG && wr_data[CFG_LOCK_BIT]) locked <= 1'b1;
      if (!locked && wr_addr == WA_LINT) usr_int <= wr_data;
      if (!locked && wr_addr == WA_LEXT) usr_ext <= wr_data;
    end
  end

  always_comb begin
    lim_vec[CH_INT] = locked ? usr_int : DEF_INT_B;
    lim_vec[CH_EXT] = locked ? usr_ext : DEF_EXT_B;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R3
  AST_LIMITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(usr_int) && $stable(usr_ext))); // R3
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import thermtrip_pkg::*;
#(
  parameter int QUAL = 3,
  parameter int HYST = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  temp_t temp,
  input  temp_t limit,
  output logic  tripped
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL - 1);

  logic [CW-1:0]     cnt;
  logic signed [8:0] rel_wide;
  temp_t             rel;
  logic              over, cool;

  always_comb begin
    rel_wide = $signed({limit[7], limit}) - $signed(9'(HYST));
    rel      = (rel_wide < -9'sd128) ? -8'sd128 : rel_wide[7:0];
    over     = temp > limit;
    cool     = temp <= rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      cnt     <= '0;
    end else if (fire) begin
      if ((!tripped && over) || (tripped && cool)) begin
        if (cnt == CNT_LAST) begin
          tripped <= !tripped;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  AST_TRIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(fire && over)); // R4
  AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> $past(fire && cool)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(tripped)); // R4
endmodule

// File: rtl/tt_fan_override.sv
module tt_fan_override
  import thermtrip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       therm,
  output logic [7:0] fan_code,
  output logic       fan_off_n
);
  logic [7:0] fan_reg;
  logic       fan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fan_reg <= 8'h00;
      fan_en  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == WA_FAN) fan_reg <= wr_data;
      if (wr_addr == WA_CFG && !therm) fan_en <= wr_data[CFG_FAN_BIT];
    end
  end

  assign fan_code  = therm ? 8'hFF : fan_reg;
  assign fan_off_n = therm | fan_en;

  AST_FAN_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    therm |=> $stable(fan_en)); // R8
endmodule

// File: rtl/thermtrip_fan_guard.sv
module thermtrip_fan_guard
  import thermtrip_pkg::*;
#(
  parameter int QUAL    = 3,
  parameter int HYST    = 5,
  parameter int DEF_INT = 70,
  parameter int DEF_EXT = 100,
  parameter int RST_INT = 127,
  parameter int RST_EXT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  output logic       smp_ready,
  input  logic       smp_chan,
  input  logic [7:0] smp_temp,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       therm_a_n,
  output logic       therm_b_n,
  output logic       irq_therm_n,
  output logic [7:0] fan_code,
  output logic       fan_off_n,
  output logic       alert_ext,
  output logic       therm_evt
);
  logic [NCHAN-1:0][7:0] lim_vec;
  logic [NCHAN-1:0]      trip_vec;
  logic                  locked;
  logic                  therm, therm_d;

  assign smp_ready = 1'b1;

  tt_limit_bank #(
    .DEF_INT(DEF_INT), .DEF_EXT(DEF_EXT), .RST_INT(RST_INT), .RST_EXT(RST_EXT)
  ) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lim_vec(lim_vec), .locked(locked)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    tt_channel #(.QUAL(QUAL), .HYST(HYST)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .fire(smp_valid && (smp_chan == 1'(c))),
      .temp(smp_temp), .limit(lim_vec[c]), .tripped(trip_vec[c])
    );
  end

  assign therm = |trip_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm_d <= 1'b0;
    else        therm_d <= therm;
  end

  tt_fan_override u_fan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .therm(therm), .fan_code(fan_code), .fan_off_n(fan_off_n)
  );

  assign therm_a_n   = !therm;
  assign therm_b_n   = !therm;
  assign irq_therm_n = !therm;
  assign alert_ext   = trip_vec[CH_EXT];
  assign therm_evt   = therm & ~therm_d;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    therm_evt |=> !therm_evt); // R9
  AST_LOCK_FREEZES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(lim_vec)); // R3
endmodule

// File: tb/sim_thermtrip_fan_guard.sv
module sim_thermtrip_fan_guard;
  logic clk = 0;
  logic rst_n = 0;
  logic smp_valid = 0, smp_chan = 0, wr_en = 0;
  logic [7:0] smp_temp = 0, wr_data = 0;
  logic [1:0] wr_addr = 0;
  logic smp_ready, therm_a_n, therm_b_n, irq_therm_n, fan_off_n, alert_ext, therm_evt;
  logic [7:0] fan_code;

  int errors = 0, checks = 0;
  int m_trip[2], m_cnt[2];
  int m_lock, m_uint, m_uext, m_fan, m_cfg5, m_prev;

  always #4 clk = ~clk;

  thermtrip_fan_guard u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_chan(smp_chan), .smp_temp(smp_temp), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .therm_a_n(therm_a_n), .therm_b_n(therm_b_n),
    .irq_therm_n(irq_therm_n), .fan_code(fan_code), .fan_off_n(fan_off_n),
    .alert_ext(alert_ext), .therm_evt(therm_evt)
  );

  function automatic int sbyte(int d);
    return (d > 127) ? d - 256 : d;
  endfunction

  function automatic int act_lim(int ch);
    if (m_lock != 0) return (ch == 0) ? m_uint : m_uext;
    return (ch == 0) ? 70 : 100;
  endfunction

  function automatic int rel_thr(int lim);
    return (lim - 5 < -128) ? -128 : lim - 5;
  endfunction

  function automatic int any_trip();
    return (m_trip[0] != 0 || m_trip[1] != 0) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_trip = '{0, 0}; m_cnt = '{0, 0};
    m_lock = 0; m_uint = 127; m_uext = 100; m_fan = 0; m_cfg5 = 0; m_prev = 0;
  endtask

  task automatic model_read(int ch, int t);
    int lim = act_lim(ch);
    int hit = (m_trip[ch] == 0) ? (t > lim) : (t <= rel_thr(lim));
    if (hit != 0) begin
      m_cnt[ch]++;
      if (m_cnt[ch] == 3) begin m_trip[ch] = 1 - m_trip[ch]; m_cnt[ch] = 0; end
    end else m_cnt[ch] = 0;
  endtask

  task automatic model_write(int a, int d);
    case (a)
      0: m_fan = d;
      1: begin
        if (d[3]) m_lock = 1;
        if (any_trip() == 0) m_cfg5 = d[5] ? 1 : 0;
      end
      2: if (m_lock == 0) m_uint = sbyte(d);
      default: if (m_lock == 0) m_uext = sbyte(d);
    endcase
  endtask

  task automatic check_all(string tg);
    int a = any_trip();
    chk(tg, int'(therm_a_n), 1 - a);
    chk("R6 therm_b", int'(therm_b_n), 1 - a);
    chk("R6 irq", int'(irq_therm_n), 1 - a);
    chk("R7 fan_code", int'(fan_code), (a != 0) ? 255 : m_fan);
    chk("R8 fan_off_n", int'(fan_off_n), (a != 0) ? 1 : m_cfg5);
    chk("R9 alert_ext", int'(alert_ext), m_trip[1]);
    chk("R9 therm_evt", int'(therm_evt), (a != 0 && m_prev == 0) ? 1 : 0);
    chk("R10 ready", int'(smp_ready), 1);
    m_prev = a;
  endtask

  task automatic do_read(int ch, int t, string tg);
    smp_valid = 1; smp_chan = 1'(ch); smp_temp = 8'(t);
    @(posedge clk);
    model_read(ch, t);
    @(negedge clk);
    smp_valid = 0;
    check_all(tg);
  endtask

  task automatic do_write(int a, int d, string tg);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 0;
    check_all(tg);
  endtask

  task automatic do_idle(string tg);
    @(posedge clk);
    @(negedge clk);
    check_all(tg);
  endtask

  task automatic do_reset();
    rst_n = 0; smp_valid = 0; wr_en = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1 therm_a", int'(therm_a_n), 1);
    chk("R1 fan_code", int'(fan_code), 0);
    chk("R1 fan_off_n", int'(fan_off_n), 0);
    chk("R1 alert", int'(alert_ext), 0);
    chk("R1 evt", int'(therm_evt), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    @(negedge clk);
    do_reset();

    // R2: equal to default limit is not over; per-channel counts (R4)
    repeat (3) do_read(1, 100, "R2");
    do_read(1, 101, "R2"); do_read(1, 101, "R2");
    do_read(0, 90, "R4");
    do_idle("R4");
    do_read(1, 101, "R2");
    chk("R2 remote tripped", int'(alert_ext), 1);
    do_read(1, 95, "R5"); do_read(1, 95, "R5"); do_read(1, 96, "R5");
    repeat (3) do_read(1, 95, "R5");
    chk("R5 remote released", int'(alert_ext), 0);
    do_read(0, 71, "R2"); do_read(0, 71, "R2");
    chk("R2 internal tripped", int'(therm_a_n), 0);
    repeat (3) do_read(0, 65, "R5");

    // R7/R8: writes during trip
    do_write(0, 8'h40, "R7");
    do_write(1, 8'h20, "R8");
    repeat (3) do_read(1, 120, "R4");
    do_write(0, 8'h55, "R7");
    do_write(1, 8'h00, "R8");
    repeat (3) do_read(1, 10, "R5");
    chk("R7 restored code", int'(fan_code), 8'h55);
    chk("R8 restored enable", int'(fan_off_n), 1);

    // R3: user limits, lock, frozen writes, saturated release (R5)
    do_write(2, 8'h83, "R3");
    do_write(3, 8'h50, "R3");
    do_write(1, 8'h08, "R3");
    do_write(3, 8'h7F, "R3");
    do_write(1, 8'h00, "R3");
    repeat (3) do_read(1, 81, "R3");
    chk("R3 user remote limit 80", int'(alert_ext), 1);
    repeat (3) do_read(1, 75, "R5");
    repeat (3) do_read(0, -100, "R3");
    chk("R3 user internal limit -125", int'(therm_a_n), 0);
    repeat (3) do_read(0, -127, "R5");
    chk("R5 no release above -128", int'(therm_a_n), 0);
    repeat (3) do_read(0, -128, "R5");
    chk("R5 saturated release", int'(therm_a_n), 1);

    // random phase after a fresh reset
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 8) do_write(0, int'($urandom_range(0, 255)), "R7");
      else if (r < 14) do_write(1, (i > 2000 && r == 13) ? 8'h28 : int'($urandom_range(0, 1)) * 32, "R8");
      else if (r < 17) do_write(int'($urandom_range(2, 3)), int'($urandom_range(40, 110)), "R3");
      else if (r < 25) do_idle("R4");
      else if (r < 60) do_read(1, int'($urandom_range(88, 110)), "R4");
      else do_read(0, int'($urandom_range(58, 80)), "R5");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule